// File: doc/BRIEF.md
# Infrared Pulse Run-Length Sampler

This block turns the single-bit output of an infrared receiver into a stream of run-length codes. The line is first optionally inverted, so a receiver that pulls low on light still reports light as a pulse. It is then passed through a short synchronizer and sampled once every `DIV` enabled clock cycles. The block counts how many consecutive samples the line keeps at one level. When the level changes, it emits one byte. Bit 7 of the byte gives the level of the finished run, and the low seven bits give its length in samples minus one.

Short glitches are absorbed into the run around them. A run of the space level that lasts longer than a programmable idle threshold ends the packet. The block then raises a one-cycle packet-end pulse, drops that idle run and stays silent until light is seen again. Storage of the codes, register access and carrier demodulation belong to the surrounding logic.

Top module: `ir_runlen_sampler`

## Requirements
- R1: One sample is taken for every `DIV` (default 64) clock cycles in which `tick_en` is high. A level held for N×`DIV` enabled cycles therefore counts as exactly N samples, and sample points are at least two cycles apart.
- R2: Each code byte puts the run level in bit 7 (1 = pulse, 0 = space) and the run length minus one in bits 6:0. `code_vld` is high for one cycle with each new byte.
- R3: When `invert` is 1, the raw line is complemented ahead of the synchronizer, so a low raw line is counted as pulse.
- R4: A level change is accepted only after the new level has lasted `noise_thr` samples (a value of 0 acts as 1). A shorter excursion emits nothing, and its samples are added to the run that surrounds it.
- R5: When a run reaches 128 samples, the byte {level, 7'h7F} is emitted and counting of the same level starts again from zero. This applies to both levels.
- R6: `pkt_end` pulses once when the space run currently being counted exceeds `idle_thr` samples. That space run is not emitted.
- R7: After reset, after re-enabling and after a packet end, no code and no packet end are produced until a pulse level is accepted.
- R8: The block samples only while `glob_en` and `rx_en` are both 1 and `mode` is 2'b11. Otherwise it emits nothing, and a run that was in progress is discarded.
- R9: A synchronous reset (`rst` high) drives `code`, `code_vld` and `pkt_end` to zero and tracks the level as space.
- R10: `pkt_end` and `code_vld` are never high in the same cycle, and `pkt_end` never lasts more than one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous reset, active high |
| ir_line | input | 1 | Raw receiver output, asynchronous |
| tick_en | input | 1 | Qualifies the cycles counted by the sample divider |
| invert | input | 1 | Complement the raw line before sampling |
| glob_en | input | 1 | Global enable |
| rx_en | input | 1 | Receive enable |
| mode | input | 2 | Operating mode; 2'b11 selects infrared receive |
| noise_thr | input | NOISE_W | Minimum accepted run in samples |
| idle_thr | input | IDLE_W | Space run length, in samples, that ends a packet |
| code | output | LEN_W+1 | Last emitted run code |
| code_vld | output | 1 | One-cycle strobe for a new code |
| pkt_end | output | 1 | One-cycle packet-end pulse |

## Verification
The checker assumes that `DIV` is at least two, so sample points never fall in back-to-back cycles. It also assumes that reset is asserted from time zero, so the first-cycle history of the sample strobe is known. The bench uses only the default divider. It changes the line, the enables and the polarity flag only in whole multiples of the sample period. When it changes the polarity, it moves the raw line at the same moment, so the sampled level does not jump. Thresholds are changed only while the block is silent after a packet end.

// File: rtl/ir_rl_pkg.sv
package ir_rl_pkg;

   typedef enum logic [1:0] {
      MODE_OFF   = 2'b00,
      MODE_RES_A = 2'b01,
      MODE_RES_B = 2'b10,
      MODE_IR_RX = 2'b11
   } ir_mode_e;

   localparam logic LVL_SPACE = 1'b0;
   localparam logic LVL_PULSE = 1'b1;

   function automatic int unsigned max_w(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/ir_rl_sync.sv
module ir_rl_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic raw,
   input  logic invert,
   output logic lvl
);
   logic pol;
   assign pol = raw ^ invert;

   generate
      if (STAGES == 0) begin : g_bypass
         assign lvl = pol;
      end else begin : g_chain
         logic [STAGES-1:0] pipe;
         always_ff @(posedge clk) begin
            if (rst) pipe <= '0;
            else     pipe <= {pipe[STAGES-2 >= 0 ? STAGES-2 : 0 : 0], pol} ;
         end
         assign lvl = pipe[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/ir_rl_prescale.sv
module ir_rl_prescale #(
   parameter int unsigned DIV = 64
) (
   input  logic clk,
   input  logic rst,
   input  logic active,
   input  logic tick_en,
   output logic strobe
);
   localparam int unsigned DIV_W = (DIV > 1) ? $clog2(DIV) : 1;
   localparam logic [DIV_W-1:0] LAST = DIV_W'(DIV - 1);

   generate
      if (DIV == 1) begin : g_direct
         assign strobe = active & tick_en;
      end else begin : g_count
         logic [DIV_W-1:0] cnt;
         always_ff @(posedge clk) begin
            if (rst || !active) begin
               cnt <= '0;
            end else if (tick_en) begin
               if (cnt == LAST) cnt <= '0;
               else             cnt <= cnt + DIV_W'(1);
            end
         end
         assign strobe = active & tick_en & (cnt == LAST);
      end
   endgenerate
endmodule

// File: rtl/ir_rl_runfsm.sv
module ir_rl_runfsm
   import ir_rl_pkg::*;
#(
   parameter int unsigned LEN_W   = 7,
   parameter int unsigned NOISE_W = 6,
   parameter int unsigned IDLE_W  = 8
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               active,
   input  logic               strobe,
   input  logic               lvl,
   input  logic [NOISE_W-1:0] noise_thr,
   input  logic [IDLE_W-1:0]  idle_thr,
   output logic [LEN_W:0]     code,
   output logic               code_vld,
   output logic               pkt_end
);
   localparam int unsigned SUM_W = max_w(LEN_W, NOISE_W) + 1;
   localparam int unsigned IC_W  = max_w(IDLE_W, NOISE_W) + 1;
   localparam logic [SUM_W-1:0] RUN_MAX = SUM_W'(2 ** LEN_W);

   // tracked state
   logic               cur_lvl, quiet;
   logic [SUM_W-1:0]   cnt;
   logic [NOISE_W-1:0] cand;
   logic [IC_W-1:0]    idle_cnt;

   // next state
   logic               n_lvl, n_quiet;
   logic [SUM_W-1:0]   n_cnt;
   logic [NOISE_W-1:0] n_cand;
   logic [IC_W-1:0]    n_idle;
   logic               emit, finish;
   logic [LEN_W:0]     emit_code;

   logic [NOISE_W-1:0] thr_eff;
   logic [SUM_W-1:0]   step, sum;
   logic [IC_W-1:0]    isum;

   assign thr_eff = (noise_thr == '0) ? NOISE_W'(1) : noise_thr;
   assign step    = SUM_W'(cand) + SUM_W'(1);
   assign sum     = cnt + step;
   assign isum    = idle_cnt + IC_W'(cand) + IC_W'(1);

   always_comb begin
      n_lvl     = cur_lvl;
      n_quiet   = quiet;
      n_cnt     = cnt;
      n_cand    = cand;
      n_idle    = idle_cnt;
      emit      = 1'b0;
      finish    = 1'b0;
      emit_code = '0;
      if (strobe) begin
         if (lvl == cur_lvl) begin
            // run continues; any pending excursion is merged into it
            n_cand = '0;
            if (!quiet) begin
               if (cur_lvl == LVL_SPACE && isum > IC_W'(idle_thr)) begin
                  finish  = 1'b1;
                  n_quiet = 1'b1;
                  n_cnt   = '0;
                  n_idle  = '0;
               end else begin
                  if (cur_lvl == LVL_SPACE) n_idle = isum;
                  if (sum >= RUN_MAX) begin
                     emit      = 1'b1;
                     emit_code = {cur_lvl, {LEN_W{1'b1}}};
                     n_cnt     = sum - RUN_MAX;
                  end else begin
                     n_cnt = sum;
                  end
               end
            end
         end else if (step >= SUM_W'(thr_eff)) begin
            // new level confirmed: close the old run
            if (!quiet && cnt != '0) begin
               emit      = 1'b1;
               emit_code = {cur_lvl, LEN_W'(cnt - SUM_W'(1))};
            end
            n_lvl   = lvl;
            n_cnt   = step;
            n_cand  = '0;
            n_quiet = 1'b0;
            n_idle  = (lvl == LVL_SPACE) ? IC_W'(step) : '0;
         end else begin
            n_cand = cand + NOISE_W'(1);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst || !active) begin
         cur_lvl  <= LVL_SPACE;
         quiet    <= 1'b1;
         cnt      <= '0;
         cand     <= '0;
         idle_cnt <= '0;
         code_vld <= 1'b0;
         pkt_end  <= 1'b0;
         if (rst) code <= '0;
      end else begin
         cur_lvl  <= n_lvl;
         quiet    <= n_quiet;
         cnt      <= n_cnt;
         cand     <= n_cand;
         idle_cnt <= n_idle;
         code_vld <= emit;
         pkt_end  <= finish;
         if (emit) code <= emit_code;
      end
   end
endmodule

// File: rtl/ir_runlen_sampler.sv
module ir_runlen_sampler
   import ir_rl_pkg::*;
#(
   parameter int unsigned DIV         = 64,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned LEN_W       = 7,
   parameter int unsigned NOISE_W     = 6,
   parameter int unsigned IDLE_W      = 8
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               ir_line,
   input  logic               tick_en,
   input  logic               invert,
   input  logic               glob_en,
   input  logic               rx_en,
   input  logic [1:0]         mode,
   input  logic [NOISE_W-1:0] noise_thr,
   input  logic [IDLE_W-1:0]  idle_thr,
   output logic [LEN_W:0]     code,
   output logic               code_vld,
   output logic               pkt_end
);
   generate
      if (DIV < 2) begin : g_bad_div
         $error("DIV must be at least 2");
      end
      if (NOISE_W > LEN_W) begin : g_bad_noise
         $error("NOISE_W must not exceed LEN_W");
      end
      if (SYNC_STAGES == 1) begin : g_bad_sync
         $error("SYNC_STAGES must be 0 or at least 2");
      end
   endgenerate

   logic active, samp_stb, lvl;

   assign active = glob_en & rx_en & (mode == MODE_IR_RX);

   ir_rl_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .raw(ir_line), .invert(invert), .lvl(lvl)
   );

   ir_rl_prescale #(.DIV(DIV)) u_pre (
      .clk(clk), .rst(rst), .active(active), .tick_en(tick_en), .strobe(samp_stb)
   );

   ir_rl_runfsm #(.LEN_W(LEN_W), .NOISE_W(NOISE_W), .IDLE_W(IDLE_W)) u_run (
      .clk(clk), .rst(rst), .active(active), .strobe(samp_stb), .lvl(lvl),
      .noise_thr(noise_thr), .idle_thr(idle_thr),
      .code(code), .code_vld(code_vld), .pkt_end(pkt_end)
   );
endmodule

// File: rtl/ir_rl_chk.sv
module ir_rl_chk (
   input logic clk,
   input logic rst,
   input logic active,
   input logic strobe,
   input logic code_vld,
   input logic pkt_end
);
   // R1: outputs only follow a sample point
   p_out_after_tick_r1: assert property (@(posedge clk) disable iff (rst)
      (code_vld || pkt_end) |-> $past(strobe));

   // R1: sample points are never adjacent
   p_tick_spacing_r1: assert property (@(posedge clk) disable iff (rst)
      strobe |=> !strobe);

   // R8: nothing comes out while disabled
   p_silent_off_r8: assert property (@(posedge clk) disable iff (rst)
      !active |=> (!code_vld && !pkt_end));

   // R10: packet end and code strobe are exclusive
   p_excl_r10: assert property (@(posedge clk) disable iff (rst)
      pkt_end |-> !code_vld);

   // R10: packet end lasts a single cycle
   p_single_pkt_r10: assert property (@(posedge clk) disable iff (rst)
      pkt_end |=> !pkt_end);
endmodule

bind ir_runlen_sampler ir_rl_chk u_chk (
   .clk(clk), .rst(rst), .active(active), .strobe(samp_stb),
   .code_vld(code_vld), .pkt_end(pkt_end)
);

// File: tb/ir_runlen_sampler_tb.sv
module ir_runlen_sampler_tb;
   localparam int DIV = 64;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       ir_line = 1'b0;
   logic       tick_en = 1'b1;
   logic       invert = 1'b0;
   logic       glob_en = 1'b1;
   logic       rx_en = 1'b1;
   logic [1:0] mode = 2'b11;
   logic [5:0] noise_thr = 6'd1;
   logic [7:0] idle_thr = 8'd20;
   logic [7:0] code;
   logic       code_vld, pkt_end;
   logic       slow = 1'b0;

   int n_chk = 0;
   int n_err = 0;
   int got_pk = 0;
   logic [7:0] got_q[$];
   logic [7:0] exp_q[$];

   always #4 clk = ~clk;

   ir_runlen_sampler u_dut (
      .clk(clk), .rst(rst), .ir_line(ir_line), .tick_en(tick_en), .invert(invert),
      .glob_en(glob_en), .rx_en(rx_en), .mode(mode), .noise_thr(noise_thr),
      .idle_thr(idle_thr), .code(code), .code_vld(code_vld), .pkt_end(pkt_end)
   );

   always @(negedge clk) begin
      tick_en <= slow ? ~tick_en : 1'b1;
      if (!rst) begin
         if (code_vld) got_q.push_back(code);
         if (pkt_end) got_pk++;
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic hold(input logic v, input int nsamp);
      @(negedge clk);
      ir_line = v;
      repeat (nsamp * DIV * (slow ? 2 : 1) - 1) @(negedge clk);
   endtask

   task automatic cmp(input string tag, input int epk);
      repeat (4) @(negedge clk);
      chk($sformatf("%s code count", tag), got_q.size(), exp_q.size());
      for (int i = 0; i < got_q.size() && i < exp_q.size(); i++)
         chk($sformatf("%s code %0d", tag, i), got_q[i], exp_q[i]);
      chk($sformatf("%s packet ends", tag), got_pk, epk);
      got_q.delete();
      exp_q.delete();
      got_pk = 0;
   endtask

   task automatic t_reset();
      repeat (5) @(negedge clk);
      chk("R9 code after reset", code, 0);
      chk("R9 code_vld after reset", code_vld, 0);
      chk("R9 pkt_end after reset", pkt_end, 0);
      rst = 1'b0;
      hold(0, 30);
      cmp("R7 idle after reset", 0);
   endtask

   task automatic t_basic();
      hold(1, 5); hold(0, 3); hold(1, 10); hold(0, 30);
      exp_q.push_back(8'h84); exp_q.push_back(8'h02); exp_q.push_back(8'h89);
      cmp("R2 R6 basic runs", 1);
   endtask

   task automatic t_quiet();
      hold(0, 100);
      cmp("R7 silent after packet end", 0);
      hold(1, 4); hold(0, 25);
      exp_q.push_back(8'h83);
      cmp("R7 resume on pulse", 1);
   endtask

   task automatic t_sat();
      hold(1, 200); hold(0, 25);
      exp_q.push_back(8'hFF); exp_q.push_back(8'hC7);
      cmp("R5 long pulse", 1);
      idle_thr = 8'd200;
      hold(1, 2); hold(0, 150); hold(1, 2); hold(0, 250);
      exp_q.push_back(8'h81); exp_q.push_back(8'h7F); exp_q.push_back(8'h15);
      exp_q.push_back(8'h81); exp_q.push_back(8'h7F);
      cmp("R5 R6 long space", 1);
      idle_thr = 8'd20;
   endtask

   task automatic t_noise();
      noise_thr = 6'd3;
      hold(1, 2); hold(0, 5);
      cmp("R4 glitch while quiet", 0);
      hold(1, 6); hold(0, 2); hold(1, 6); hold(0, 3); hold(1, 4); hold(0, 25);
      exp_q.push_back(8'h8D); exp_q.push_back(8'h02); exp_q.push_back(8'h83);
      cmp("R4 merged glitch", 1);
      noise_thr = 6'd1;
   endtask

   task automatic t_invert();
      @(negedge clk);
      invert = 1'b1; ir_line = 1'b1;
      hold(0, 5); hold(1, 25);
      exp_q.push_back(8'h84);
      cmp("R3 inverted line", 1);
      @(negedge clk);
      invert = 1'b0; ir_line = 1'b0;
      hold(0, 5);
      cmp("R3 restore", 0);
   endtask

   task automatic t_slow();
      slow = 1'b1;
      hold(1, 6); hold(0, 25);
      slow = 1'b0;
      exp_q.push_back(8'h85);
      cmp("R1 half-rate tick", 1);
   endtask

   task automatic t_enable();
      hold(1, 10);
      @(negedge clk);
      rx_en = 1'b0; ir_line = 1'b0;
      hold(0, 10);
      rx_en = 1'b1;
      hold(0, 5); hold(1, 3); hold(0, 25);
      exp_q.push_back(8'h82);
      cmp("R8 run dropped on disable", 1);
      mode = 2'b00;
      hold(1, 5); hold(0, 25);
      cmp("R8 wrong mode", 0);
      mode = 2'b11; glob_en = 1'b0;
      hold(1, 5); hold(0, 25);
      cmp("R8 global off", 0);
      glob_en = 1'b1;
      hold(0, 5);
   endtask

   initial begin
      t_reset();
      t_basic();
      t_quiet();
      t_sat();
      t_noise();
      t_invert();
      t_slow();
      t_enable();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule